// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block connects a 32-bit configuration register port to an internal sideband request/response bus. Software stages write data in a data register. It can also load the upper 24 address bits into an extension register. It then writes a command word that holds an opcode, a target unit number and the low address byte. That command write acts as a doorbell: it produces exactly one sideband request. When the request is a read, the returned word is placed in the data register, where software can fetch it.

A status register reports a busy flag and a sticky error flag. The error flag is raised in three cases:
- a command is aimed at the reserved graphics unit;
- a command is written while a transaction is still open;
- the target answers with an error.

A masked update is not a hardware operation. Software performs it as a read followed by a write to the same unit and address, merging the old and new values itself.

Top module: `sb_mbox_bridge`

## Requirements
- R1: After reset, busy and error read as 0, the data register (offset 0xD4) and the extension register (offset 0xD8) read 0, and no sideband request is valid.
- R2: A write to the command register (offset 0xD0) while idle, with a unit number other than 0x06, issues one sideband request. The request fields are taken as follows: opcode from command bits 31:24, unit from bits 23:16, byte enables from bits 7:4, address from {extension bits 31:8, command bits 15:8}, and write data from the data register.
- R3: While a request is valid and not accepted, it stays valid and its opcode, unit, address, byte enables and data do not change.
- R4: When the opcode has bit 0 clear (a read), a good response loads its data into the data register. When bit 0 is set (a write), the data register keeps its value.
- R5: The extension register stores only address bits 31:8, and its bits 7:0 read as zero. It is cleared when a command is launched, so a later command that does not reload it uses zero upper address bits.
- R6: Busy (status bit 0) is set from the edge that accepts the command until the edge that takes the response.
- R7: A command to unit 0x06 issues no request, leaves busy at 0, and sets the error flag.
- R8: A command written while busy is dropped (no request follows) and sets the error flag.
- R9: A response with its error bit set raises the error flag and leaves the data register unchanged.
- R10: The status register (offset 0xDC) shows error on bit 1 and busy on bit 0. Writing 1 to bit 1 clears the error flag, except when a new error event occurs in the same cycle; in that case the flag stays set.
- R11: While busy, reads of the data register return the value it held before the command.
- R12: A masked modify, built as a read followed by a write of (old & ~mask) | (new & mask) to the same unit and address, leaves that merged value at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_addr_i | input | 8 | Configuration register offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data, combinational on cfg_addr_i |
| sb_req_valid_o | output | 1 | Sideband request valid |
| sb_req_ready_i | input | 1 | Sideband request accepted |
| sb_req_opcode_o | output | 8 | Request opcode |
| sb_req_port_o | output | 8 | Target unit number |
| sb_req_addr_o | output | 32 | Full register address |
| sb_req_be_o | output | 4 | Byte enables |
| sb_req_wdata_o | output | 32 | Request write data |
| sb_rsp_valid_i | input | 1 | Response valid |
| sb_rsp_rdata_i | input | 32 | Response read data |
| sb_rsp_err_i | input | 1 | Response error |
| busy_o | output | 1 | Transaction outstanding |
| err_o | output | 1 | Sticky error flag |

## Verification
Two events can fall in the same cycle: a response carrying an error, and a software write that clears the error flag. The bench provokes this by launching a read to a unit whose responder always answers with an error. The response delay is set to one cycle, so the response lands on exactly the edge where the status clear is written. The flag must still read 1 afterwards, and a second clear with no competing event must then drop it to 0. Scoreboarding of the sideband requests is used to judge the dropped-doorbell cases (reserved unit, command while busy): any request that appears without an expected entry is reported.

// File: rtl/sb_mbox_pkg.sv
package sb_mbox_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned OPW  = 8;
  localparam int unsigned PW   = 8;
  localparam int unsigned BEW  = 4;
  localparam int unsigned LOW  = 8;
  localparam int unsigned HIW  = DW - LOW;
  localparam int unsigned OFSW = 8;

  localparam logic [OFSW-1:0] OFS_CMD  = 8'hD0;
  localparam logic [OFSW-1:0] OFS_DATA = 8'hD4;
  localparam logic [OFSW-1:0] OFS_EXT  = 8'hD8;
  localparam logic [OFSW-1:0] OFS_STAT = 8'hDC;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_ERR_BIT  = 1;

  typedef struct packed {
    logic [OPW-1:0] opcode;
    logic [PW-1:0]  port;
    logic [DW-1:0]  addr;
    logic [BEW-1:0] be;
    logic [DW-1:0]  wdata;
  } sb_req_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} sb_state_e;
endpackage

// File: rtl/sb_mbox_regs.sv
module sb_mbox_regs
  import sb_mbox_pkg::*;
#(
  parameter logic [PW-1:0] RSVD_PORT = 8'h06
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_wr_i,
  input  logic [OFSW-1:0] cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic [DW-1:0]   cfg_rdata_o,
  input  logic            busy_i,
  input  logic            done_i,
  input  logic            done_rd_i,
  input  logic [DW-1:0]   rsp_rdata_i,
  input  logic            rsp_err_i,
  output logic            launch_o,
  output sb_req_t         req_o,
  output logic            err_o
);
  logic [DW-1:0]  data_q;
  logic [HIW-1:0] ext_q;
  logic           err_q;
  logic           wr_cmd, wr_data, wr_ext, wr_stat, rsvd_hit, err_set, err_clr;

  assign wr_cmd   = cfg_wr_i && (cfg_addr_i == OFS_CMD);
  assign wr_data  = cfg_wr_i && (cfg_addr_i == OFS_DATA);
  assign wr_ext   = cfg_wr_i && (cfg_addr_i == OFS_EXT);
  assign wr_stat  = cfg_wr_i && (cfg_addr_i == OFS_STAT);
  assign rsvd_hit = cfg_wdata_i[23:16] == RSVD_PORT;
  assign launch_o = wr_cmd && !busy_i && !rsvd_hit;

  // a fresh error event outranks a software clear in the same cycle
  assign err_set = (wr_cmd && (busy_i || rsvd_hit)) || (done_i && rsp_err_i);
  assign err_clr = wr_stat && cfg_wdata_i[STAT_ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ext_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (done_i && done_rd_i && !rsp_err_i) data_q <= rsp_rdata_i;
      else if (wr_data)                      data_q <= cfg_wdata_i;

      if (launch_o)    ext_q <= '0;
      else if (wr_ext) ext_q <= cfg_wdata_i[DW-1:LOW];

      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    req_o.opcode = cfg_wdata_i[31:24];
    req_o.port   = cfg_wdata_i[23:16];
    req_o.addr   = {ext_q, cfg_wdata_i[15:8]};
    req_o.be     = cfg_wdata_i[7:4];
    req_o.wdata  = data_q;
  end

  always_comb begin
    unique case (cfg_addr_i)
      OFS_DATA: cfg_rdata_o = data_q;
      OFS_EXT:  cfg_rdata_o = {ext_q, {LOW{1'b0}}};
      OFS_STAT: cfg_rdata_o = {{(DW-2){1'b0}}, err_q, busy_i};
      default:  cfg_rdata_o = '0;
    endcase
  end

  assign err_o = err_q;
endmodule

// File: rtl/sb_mbox_seq.sv
module sb_mbox_seq
  import sb_mbox_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    launch_i,
  input  sb_req_t req_i,
  input  logic    ready_i,
  input  logic    rsp_valid_i,
  output logic    valid_o,
  output sb_req_t req_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    done_rd_o
);
  sb_state_e state_q;
  sb_req_t   req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          req_q   <= req_i;
          state_q <= ST_REQ;
        end
        ST_REQ:  if (ready_i) state_q <= ST_RSP;
        ST_RSP:  if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o   = state_q == ST_REQ;
  assign req_o     = req_q;
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = (state_q == ST_RSP) && rsp_valid_i;
  assign done_rd_o = !req_q.opcode[0];
endmodule

// File: rtl/sb_mbox_bridge.sv
module sb_mbox_bridge
  import sb_mbox_pkg::*;
#(
  parameter logic [PW-1:0] RSVD_PORT = 8'h06
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_wr_i,
  input  logic [OFSW-1:0] cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic [DW-1:0]   cfg_rdata_o,
  output logic            sb_req_valid_o,
  input  logic            sb_req_ready_i,
  output logic [OPW-1:0]  sb_req_opcode_o,
  output logic [PW-1:0]   sb_req_port_o,
  output logic [DW-1:0]   sb_req_addr_o,
  output logic [BEW-1:0]  sb_req_be_o,
  output logic [DW-1:0]   sb_req_wdata_o,
  input  logic            sb_rsp_valid_i,
  input  logic [DW-1:0]   sb_rsp_rdata_i,
  input  logic            sb_rsp_err_i,
  output logic            busy_o,
  output logic            err_o
);
  logic    launch, busy, done, done_rd;
  sb_req_t new_req, cur_req;

  sb_mbox_regs #(.RSVD_PORT(RSVD_PORT)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .done_rd_i   (done_rd),
    .rsp_rdata_i (sb_rsp_rdata_i),
    .rsp_err_i   (sb_rsp_err_i),
    .launch_o    (launch),
    .req_o       (new_req),
    .err_o       (err_o)
  );

  sb_mbox_seq seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .req_i       (new_req),
    .ready_i     (sb_req_ready_i),
    .rsp_valid_i (sb_rsp_valid_i),
    .valid_o     (sb_req_valid_o),
    .req_o       (cur_req),
    .busy_o      (busy),
    .done_o      (done),
    .done_rd_o   (done_rd)
  );

  assign sb_req_opcode_o = cur_req.opcode;
  assign sb_req_port_o   = cur_req.port;
  assign sb_req_addr_o   = cur_req.addr;
  assign sb_req_be_o     = cur_req.be;
  assign sb_req_wdata_o  = cur_req.wdata;
  assign busy_o          = busy;
endmodule

// File: rtl/sb_mbox_bridge_chk.sv
module sb_mbox_bridge_chk
  import sb_mbox_pkg::*;
#(
  parameter logic [PW-1:0] RSVD_PORT = 8'h06
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_wr_i,
  input logic [OFSW-1:0] cfg_addr_i,
  input logic [DW-1:0]   cfg_wdata_i,
  input logic            sb_req_valid_o,
  input logic            sb_req_ready_i,
  input logic [OPW-1:0]  sb_req_opcode_o,
  input logic [PW-1:0]   sb_req_port_o,
  input logic [DW-1:0]   sb_req_addr_o,
  input logic [BEW-1:0]  sb_req_be_o,
  input logic [DW-1:0]   sb_req_wdata_o,
  input logic            sb_rsp_valid_i,
  input logic            sb_rsp_err_i,
  input logic            busy_o,
  input logic            err_o
);
  logic cmd_wr, clr_wr, in_rsp;
  assign cmd_wr = cfg_wr_i && (cfg_addr_i == OFS_CMD);
  assign clr_wr = cfg_wr_i && (cfg_addr_i == OFS_STAT) && cfg_wdata_i[STAT_ERR_BIT];
  assign in_rsp = busy_o && !sb_req_valid_o;

  AST_LAUNCH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !busy_o && (cfg_wdata_i[23:16] != RSVD_PORT) |=> sb_req_valid_o && busy_o); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_req_valid_o && !sb_req_ready_i |=> sb_req_valid_o && $stable(sb_req_addr_o) &&
      $stable(sb_req_wdata_o) && $stable(sb_req_opcode_o) && $stable(sb_req_port_o) &&
      $stable(sb_req_be_o)); // R3
  AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_req_valid_o |-> busy_o); // R6
  AST_RSP_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rsp && sb_rsp_valid_i |=> !busy_o); // R6
  AST_NO_RSVD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_req_valid_o |-> sb_req_port_o != RSVD_PORT); // R7
  AST_RSVD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && (cfg_wdata_i[23:16] == RSVD_PORT) |=> err_o); // R7
  AST_BUSY_CMD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && busy_o |=> err_o); // R8
  AST_RSP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rsp && sb_rsp_valid_i && sb_rsp_err_i |=> err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_wr |=> err_o); // R10
endmodule

bind sb_mbox_bridge sb_mbox_bridge_chk #(.RSVD_PORT(RSVD_PORT)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_wr_i        (cfg_wr_i),
  .cfg_addr_i      (cfg_addr_i),
  .cfg_wdata_i     (cfg_wdata_i),
  .sb_req_valid_o  (sb_req_valid_o),
  .sb_req_ready_i  (sb_req_ready_i),
  .sb_req_opcode_o (sb_req_opcode_o),
  .sb_req_port_o   (sb_req_port_o),
  .sb_req_addr_o   (sb_req_addr_o),
  .sb_req_be_o     (sb_req_be_o),
  .sb_req_wdata_o  (sb_req_wdata_o),
  .sb_rsp_valid_i  (sb_rsp_valid_i),
  .sb_rsp_err_i    (sb_rsp_err_i),
  .busy_o          (busy_o),
  .err_o           (err_o)
);

// File: tb/sb_mbox_bridge_tb_top.sv
module sb_mbox_bridge_tb_top;
  import sb_mbox_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_opcode, req_port;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        busy, err;

  always #5 clk = ~clk;

  sb_mbox_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .sb_req_valid_o(req_valid), .sb_req_ready_i(req_ready),
    .sb_req_opcode_o(req_opcode), .sb_req_port_o(req_port),
    .sb_req_addr_o(req_addr), .sb_req_be_o(req_be), .sb_req_wdata_o(req_wdata),
    .sb_rsp_valid_i(rsp_valid), .sb_rsp_rdata_i(rsp_rdata), .sb_rsp_err_i(rsp_err),
    .busy_o(busy), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  sb_req_t exp_q[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] shadow_data = '0;
  int stall_cycles = 0, rsp_delay = 1;
  localparam logic [7:0] ERR_PORT = 8'hEE;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_0000);
  endfunction

  // responder and monitor
  int stall_left = 0, rsp_cnt = 0;
  bit stalling = 0;
  sb_req_t held;
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin rsp_valid = 1'b0; rsp_err = 1'b0; end
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) rsp_valid = 1'b1;
      end
      if (req_ready) req_ready = 1'b0;
      else if (req_valid) begin
        if (!stalling) begin
          stalling = 1; stall_left = stall_cycles;
          held = '{req_opcode, req_port, req_addr, req_be, req_wdata};
        end else begin
          check("R3 held request", {req_addr ^ req_wdata}, {held.addr ^ held.wdata});
          check("R3 held ctl", {12'h0, req_opcode, req_port, req_be},
                {12'h0, held.opcode, held.port, held.be});
        end
        if (stall_left > 0) stall_left--;
        else begin
          stalling = 0;
          req_ready = 1'b1;
          if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7/R8 unexpected request actual=%h expected=none", req_addr);
          end else begin
            sb_req_t e;
            e = exp_q.pop_front();
            check("R2 opcode", {24'h0, req_opcode}, {24'h0, e.opcode});
            check("R2 port", {24'h0, req_port}, {24'h0, e.port});
            check("R2 addr", req_addr, e.addr);
            check("R2 be", {28'h0, req_be}, {28'h0, e.be});
            check("R2 wdata", req_wdata, e.wdata);
          end
          rsp_err   = (req_port == ERR_PORT);
          rsp_rdata = model_rd(req_addr);
          if (req_opcode[0] && !rsp_err) mem[req_addr] = req_wdata;
          rsp_cnt = rsp_delay;
        end
      end
    end
  end

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == OFS_DATA && !busy) shadow_data = d;
  endtask

  task automatic cfg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] port, logic [31:0] a, bit use_ext);
    if (use_ext) cfg_write(OFS_EXT, a);
    exp_q.push_back('{op, port, a, 4'hF, shadow_data});
    cfg_write(OFS_CMD, {op, port, a[7:0], 4'hF, 4'h0});
  endtask

  task automatic mb_write(logic [7:0] port, logic [31:0] a, logic [31:0] d);
    cfg_write(OFS_DATA, d);
    issue(8'h07, port, a, 1);
    wait_idle();
  endtask

  task automatic mb_read(logic [7:0] port, logic [31:0] a, bit use_ext, output logic [31:0] d);
    logic [31:0] e;
    e = model_rd(a);
    issue(8'h06, port, a, use_ext);
    wait_idle();
    if (port != ERR_PORT) shadow_data = e;
    cfg_read(OFS_DATA, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 err", {31'h0, err}, 32'h0);
    check("R1 valid", {31'h0, req_valid}, 32'h0);
    cfg_read(OFS_DATA, r); check("R1 data", r, 32'h0);
    cfg_read(OFS_EXT, r);  check("R1 ext", r, 32'h0);
    rst_n = 1'b1;

    // write, busy window, ext clear
    cfg_write(OFS_DATA, 32'hCAFE_F00D);
    issue(8'h07, 8'h04, 32'h0000_1234, 1);
    check("R6 busy after launch", {31'h0, busy}, 32'h1);
    wait_idle();
    check("R6 busy released", {31'h0, busy}, 32'h0);
    cfg_read(OFS_DATA, r); check("R4 write keeps data", r, 32'hCAFE_F00D);
    cfg_read(OFS_EXT, r);  check("R5 ext cleared", r, 32'h0);

    mb_read(8'h04, 32'h0000_1234, 1, r); check("R4 read data", r, 32'hCAFE_F00D);

    cfg_write(OFS_EXT, 32'hFFFF_FFFF);
    cfg_read(OFS_EXT, r); check("R5 ext low zero", r, 32'hFFFF_FF00);
    mb_read(8'h03, 32'hFFFF_FF34, 0, r); check("R4 read high addr", r, model_rd(32'hFFFF_FF34));
    mb_read(8'h03, 32'h0000_0034, 0, r); check("R5 no ext reload", r, model_rd(32'h0000_0034));

    // stalled acceptance
    stall_cycles = 3;
    mb_write(8'h01, 32'h00AB_CD10, 32'h1111_2222);
    stall_cycles = 0;

    // slow response: reads while busy, doorbell while busy
    rsp_delay = 6;
    cfg_write(OFS_DATA, 32'h7777_0000);
    issue(8'h06, 8'h02, 32'h0000_5500, 1);
    cfg_read(OFS_DATA, r); check("R11 data while busy", r, 32'h7777_0000);
    cfg_read(OFS_STAT, r); check("R10 status busy", r, 32'h1);
    cfg_write(OFS_CMD, {8'h07, 8'h02, 8'h11, 4'hF, 4'h0});
    check("R8 err after busy cmd", {31'h0, err}, 32'h1);
    wait_idle();
    shadow_data = model_rd(32'h0000_5500);
    cfg_read(OFS_DATA, r); check("R4 slow read data", r, model_rd(32'h0000_5500));
    repeat (4) @(negedge clk);
    check("R8 no extra request", exp_q.size(), 0);
    rsp_delay = 1;
    cfg_read(OFS_STAT, r); check("R10 status err", r, 32'h2);
    cfg_write(OFS_STAT, 32'h2);
    cfg_read(OFS_STAT, r); check("R10 w1c", r, 32'h0);

    // reserved unit
    cfg_write(OFS_CMD, {8'h01, 8'h06, 8'h20, 4'hF, 4'h0});
    check("R7 no busy", {31'h0, busy}, 32'h0);
    check("R7 err set", {31'h0, err}, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 no valid", {31'h0, req_valid}, 32'h0);
    cfg_write(OFS_STAT, 32'h2);

    // response error
    cfg_read(OFS_DATA, r);
    mb_read(ERR_PORT, 32'h0000_0040, 0, r);
    check("R9 data kept", r, shadow_data);
    check("R9 err set", {31'h0, err}, 32'h1);
    cfg_write(OFS_STAT, 32'h2);
    check("R9 err cleared", {31'h0, err}, 32'h0);

    // error response in the same cycle as a clear
    issue(8'h06, ERR_PORT, 32'h0000_0044, 0);
    cfg_write(OFS_STAT, 32'h2);
    check("R10 set beats clear", {31'h0, err}, 32'h1);
    wait_idle();
    cfg_write(OFS_STAT, 32'h2);
    check("R10 plain clear", {31'h0, err}, 32'h0);

    // masked modify
    mb_write(8'h04, 32'h0000_0300, 32'h1234_5678);
    mb_read(8'h04, 32'h0000_0300, 1, r);
    cfg_write(OFS_DATA, (r & ~32'h00FF_00F0) | (32'hAABB_CCDD & 32'h00FF_00F0));
    issue(8'h07, 8'h04, 32'h0000_0300, 1);
    wait_idle();
    mb_read(8'h04, 32'h0000_0300, 1, r); check("R12 modify result", r, 32'h12BB_56D8);

    repeat (3) @(negedge clk);
    check("R2 all requests seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule